// File: doc/BRIEF.md
# Vendor Message Capture and Hold

This block sits at the inbound side of a serial link endpoint. It takes vendor-defined messages from the posted queue and keeps one of them at a time. When an unmasked message is accepted, its four header dwords and its payload dword are latched into read-only registers, and a received flag is raised for local software. While that flag stays set, the ingress handshake refuses further messages, so they remain pending in the upstream posted queue. Software releases them either by writing 1 to the received flag or by setting the mask bit.

With the mask bit set, every vendor message is consumed in the cycle it arrives and the captured registers are not touched. A type 0 message is reported as an unsupported request through a one-clock pulse. A type 1 message is dropped with no indication at all. An interrupt output follows the received flag when interrupts are enabled and the mask is clear.

The register window uses byte offsets. The header dwords sit at 0x340, 0x344, 0x348 and 0x34C, the payload at 0x350, and the control/status word at 0x354.

Top module: `vmsg_capture`

## Requirements
- R1: When a message is accepted with the mask clear, the four header dwords and the payload are loaded into registers read at 0x340/0x344/0x348/0x34C and 0x350. Each is visible on `reg_rdata` from the following cycle. Writes to these offsets have no effect.
- R2: Header byte k arrives on `msg_hdr[127-8k -: 8]`. It is stored in header dword k/4, with the lowest-numbered byte of each dword in bits 31:24. This places byte 12 in bits 31:24 and byte 15 in bits 7:0 of the dword at 0x34C.
- R3: A capture sets the received flag, which is bit 0 of the control word at 0x354, on the clock edge of acceptance.
- R4: While the received flag is set and the mask is clear, `msg_ready` is low. A presented message then stays pending and no captured register changes. Pending messages are taken once the flag is cleared.
- R5: Writing 1 to bit 0 at 0x354 clears the received flag, and writing 0 leaves it unchanged. A capture in the same cycle as a clearing write leaves the flag set.
- R6: While the mask bit (bit 1 at 0x354) is set, `msg_ready` is high. Messages are consumed without changing the captured registers or the received flag.
- R7: A type 0 message (`msg_kind`=0) consumed while masked drives `ur_pulse` high for exactly the one cycle after the accepting edge.
- R8: A type 1 message (`msg_kind`=1) consumed while masked produces no `ur_pulse` and no other visible effect.
- R9: `vdm_irq` is high exactly when the received flag is set, the interrupt-enable bit (bit 2 at 0x354) is set and the mask bit is clear.
- R10: After reset, all captured registers and the control bits are zero, `msg_ready` is high, and `vdm_irq` and `ur_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | A vendor message is presented |
| msg_ready | output | 1 | Block takes the presented message this cycle |
| msg_kind | input | 1 | Message type: 0 = type 0, 1 = type 1 |
| msg_hdr | input | 128 | Four header dwords, byte 0 in bits 127:120 |
| msg_payload | input | 32 | Payload dword |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| vdm_irq | output | 1 | Interrupt request |
| ur_pulse | output | 1 | Unsupported-request pulse for a masked type 0 message |

## Verification
The in-RTL properties check several relations on every clock. A capture loads the presented payload and raises the received flag. A stalled or masked message leaves the payload register unchanged. A clearing write without a capture drops the flag. Every unsupported-request pulse traces back to a masked type 0 message, and a masked type 1 message never produces one. The bench scenarios must show the rest: the byte placement across the header registers, the flag staying set when a clear meets a capture, the release of a held message after a clear or a mask, and the interrupt following enable and mask changes. A cycle-accurate behavioural model compares every output against a long pseudo-random stream of traffic and register writes.

// File: rtl/vmc_pkg.sv
package vmc_pkg;

   // control/status word bit positions (software-visible)
   localparam int unsigned CTL_RCVD_BIT = 0;
   localparam int unsigned CTL_MASK_BIT = 1;
   localparam int unsigned CTL_IEN_BIT  = 2;
   localparam int unsigned CTL_BITS     = 3;

   typedef enum logic {
      VMSG_T0 = 1'b0,
      VMSG_T1 = 1'b1
   } vmsg_kind_e;

   // packed so that rcvd lands in bit 0, mask in 1, ien in 2
   typedef struct packed {
      logic ien;
      logic mask;
      logic rcvd;
   } vmc_ctl_t;

endpackage

// File: rtl/vmc_ingress_ctl.sv
module vmc_ingress_ctl
   import vmc_pkg::*;
#(
   parameter bit UR_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                msg_valid,
   input  logic                msg_kind,
   input  logic                ctl_wr,
   input  logic [CTL_BITS-1:0] ctl_wdata,
   output logic                msg_ready,
   output logic                cap_load,
   output vmc_ctl_t            ctl_q,
   output logic                ur_pulse,
   output logic                irq
);

   logic accept;
   logic drop_t0;

   // backpressure only while a capture is held and not masked
   assign msg_ready = ctl_q.mask | ~ctl_q.rcvd;
   assign accept    = msg_valid & msg_ready;
   assign cap_load  = accept & ~ctl_q.mask;
   assign drop_t0   = accept & ctl_q.mask & (vmsg_kind_e'(msg_kind) == VMSG_T0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         // a new capture takes priority over a write-1-to-clear
         if (cap_load)
            ctl_q.rcvd <= 1'b1;
         else if (ctl_wr && ctl_wdata[CTL_RCVD_BIT])
            ctl_q.rcvd <= 1'b0;
         if (ctl_wr) begin
            ctl_q.mask <= ctl_wdata[CTL_MASK_BIT];
            ctl_q.ien  <= ctl_wdata[CTL_IEN_BIT];
         end
      end
   end

   generate
      if (UR_REG) begin : g_ur_reg
         logic ur_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ur_q <= 1'b0;
            else        ur_q <= drop_t0;
         end
         assign ur_pulse = ur_q;

         AST_UR_FROM_MASKED_T0: assert property (@(posedge clk) disable iff (!rst_n)
            ur_pulse |-> $past(msg_valid && ctl_q.mask && msg_kind == 1'b0)); // R7
      end else begin : g_ur_comb
         assign ur_pulse = drop_t0;
      end
   endgenerate

   assign irq = ctl_q.rcvd & ctl_q.ien & ~ctl_q.mask;

   AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cap_load |=> ctl_q.rcvd); // R3

   AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[CTL_RCVD_BIT] && !cap_load) |=> !ctl_q.rcvd); // R5

   AST_MASK_WRITE_QUIETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[CTL_MASK_BIT]) |=> !irq); // R9

endmodule

// File: rtl/vmc_hdr_store.sv
module vmc_hdr_store #(
   parameter int unsigned DW  = 32,
   parameter int unsigned NDW = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [NDW*DW-1:0]       hdr_in,
   input  logic [DW-1:0]           pay_in,
   output logic [NDW-1:0][DW-1:0]  hdr_q,
   output logic [DW-1:0]           pay_q
);

   localparam int unsigned HDR_W = NDW * DW;

   if (DW % 8 != 0) begin : g_bad_dw
      $error("vmc_hdr_store: DW must be a whole number of bytes");
   end
   if (NDW == 0) begin : g_bad_ndw
      $error("vmc_hdr_store: NDW must be at least 1");
   end

   // dword j is taken from the top of the bus downward, so byte 0 of the
   // message ends up in the high byte of dword 0
   for (genvar j = 0; j < NDW; j++) begin : g_dw
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    hdr_q[j] <= '0;
         else if (load) hdr_q[j] <= hdr_in[HDR_W-1-j*DW -: DW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pay_q <= '0;
      else if (load) pay_q <= pay_in;
   end

   AST_LOAD_TAKES_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (pay_q == $past(pay_in))); // R1

   AST_LOAD_TAKES_LAST_DW: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (hdr_q[NDW-1] == $past(hdr_in[DW-1:0]))); // R2

endmodule

// File: rtl/vmc_reg_read.sv
module vmc_reg_read
   import vmc_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned NDW      = 4,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned HDR_BASE = 'h340
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [NDW-1:0][DW-1:0]  hdr_q,
   input  logic [DW-1:0]           pay_q,
   input  vmc_ctl_t                ctl_q,
   output logic [DW-1:0]           rdata
);

   localparam int unsigned STRIDE  = DW / 8;
   localparam int unsigned PAY_OFS = HDR_BASE + NDW * STRIDE;
   localparam int unsigned CTL_OFS = PAY_OFS + STRIDE;

   if (CTL_OFS >= (1 << ADDR_W)) begin : g_bad_map
      $error("vmc_reg_read: register window exceeds the address range");
   end

   always_comb begin
      rdata = '0;
      for (int j = 0; j < NDW; j++) begin
         if (addr == ADDR_W'(HDR_BASE + j * STRIDE)) rdata = hdr_q[j];
      end
      if (addr == ADDR_W'(PAY_OFS)) rdata = pay_q;
      if (addr == ADDR_W'(CTL_OFS)) rdata = {{(DW-CTL_BITS){1'b0}}, ctl_q};
   end

endmodule

// File: rtl/vmsg_capture.sv
module vmsg_capture
   import vmc_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned NDW      = 4,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned HDR_BASE = 'h340,
   parameter bit          UR_REG   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                msg_valid,
   output logic                msg_ready,
   input  logic                msg_kind,
   input  logic [NDW*DW-1:0]   msg_hdr,
   input  logic [DW-1:0]       msg_payload,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [DW-1:0]       reg_wdata,
   output logic [DW-1:0]       reg_rdata,
   output logic                vdm_irq,
   output logic                ur_pulse
);

   localparam int unsigned STRIDE  = DW / 8;
   localparam int unsigned CTL_OFS = HDR_BASE + (NDW + 1) * STRIDE;

   if (DW < CTL_BITS) begin : g_bad_width
      $error("vmsg_capture: DW too narrow for the control word");
   end
   if (HDR_BASE % STRIDE != 0) begin : g_bad_base
      $error("vmsg_capture: HDR_BASE must be dword aligned");
   end

   logic                   ctl_wr;
   logic                   cap_load;
   vmc_ctl_t               ctl_q;
   logic [NDW-1:0][DW-1:0] hdr_q;
   logic [DW-1:0]          pay_q;
   logic                   unused_wdata;

   assign ctl_wr       = reg_wr && (reg_addr == ADDR_W'(CTL_OFS));
   assign unused_wdata = ^reg_wdata[DW-1:CTL_BITS];

   vmc_ingress_ctl #(
      .UR_REG (UR_REG)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .msg_valid (msg_valid),
      .msg_kind  (msg_kind),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (reg_wdata[CTL_BITS-1:0]),
      .msg_ready (msg_ready),
      .cap_load  (cap_load),
      .ctl_q     (ctl_q),
      .ur_pulse  (ur_pulse),
      .irq       (vdm_irq)
   );

   vmc_hdr_store #(
      .DW  (DW),
      .NDW (NDW)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cap_load),
      .hdr_in (msg_hdr),
      .pay_in (msg_payload),
      .hdr_q  (hdr_q),
      .pay_q  (pay_q)
   );

   vmc_reg_read #(
      .DW       (DW),
      .NDW      (NDW),
      .ADDR_W   (ADDR_W),
      .HDR_BASE (HDR_BASE)
   ) u_rd (
      .addr  (reg_addr),
      .hdr_q (hdr_q),
      .pay_q (pay_q),
      .ctl_q (ctl_q),
      .rdata (reg_rdata)
   );

   AST_STALL_HOLDS_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> $stable(pay_q)); // R4

   AST_MASKED_HOLDS_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && ctl_q.mask) |=> $stable(pay_q)); // R6

   AST_T1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(msg_valid && ctl_q.mask && msg_kind == 1'b1) |-> !ur_pulse); // R8

endmodule

// File: tb/tb_vmsg_capture.sv
`timescale 1ns/100ps
module tb_vmsg_capture;

   localparam logic [11:0] A_H0  = 12'h340;
   localparam logic [11:0] A_H3  = 12'h34C;
   localparam logic [11:0] A_PAY = 12'h350;
   localparam logic [11:0] A_CTL = 12'h354;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         msg_valid = 1'b0;
   logic         msg_ready;
   logic         msg_kind = 1'b0;
   logic [127:0] msg_hdr = '0;
   logic [31:0]  msg_payload = '0;
   logic [11:0]  reg_addr = '0;
   logic         reg_wr = 1'b0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         vdm_irq;
   logic         ur_pulse;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   vmsg_capture dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .msg_valid   (msg_valid),
      .msg_ready   (msg_ready),
      .msg_kind    (msg_kind),
      .msg_hdr     (msg_hdr),
      .msg_payload (msg_payload),
      .reg_addr    (reg_addr),
      .reg_wr      (reg_wr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .vdm_irq     (vdm_irq),
      .ur_pulse    (ur_pulse)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_hdr [4];
   logic [31:0] m_pay;
   bit m_rcvd, m_mask, m_ien, m_ur;

   function automatic logic [31:0] m_read(input logic [11:0] a);
      if (a >= A_H0 && a <= A_H3 && a[1:0] == 2'b00) return m_hdr[(a - A_H0) / 4];
      if (a == A_PAY) return m_pay;
      if (a == A_CTL) return {29'd0, m_ien, m_mask, m_rcvd};
      return 32'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_hdr[i]) m_hdr[i] = '0;
         m_pay = '0; m_rcvd = 0; m_mask = 0; m_ien = 0; m_ur = 0;
      end else begin
         bit take;
         take = msg_valid && (m_mask || !m_rcvd);
         m_ur = take && m_mask && (msg_kind == 1'b0);
         if (take && !m_mask) begin
            for (int i = 0; i < 4; i++) m_hdr[i] = msg_hdr[127-32*i -: 32];
            m_pay  = msg_payload;
            m_rcvd = 1;
         end else if (reg_wr && reg_addr == A_CTL && reg_wdata[0]) begin
            m_rcvd = 0;
         end
         if (reg_wr && reg_addr == A_CTL) begin
            m_mask = reg_wdata[1];
            m_ien  = reg_wdata[2];
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 msg_ready", {31'd0, msg_ready}, {31'd0, m_mask || !m_rcvd});
         chk("R9 vdm_irq", {31'd0, vdm_irq}, {31'd0, m_rcvd && m_ien && !m_mask});
         chk("R7 ur_pulse", {31'd0, ur_pulse}, {31'd0, m_ur});
         chk("R1 reg_rdata", reg_rdata, m_read(reg_addr));
      end
   end

   task automatic finish_up();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         fails++;
         $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
         finish_up();
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle();
      msg_valid = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic put_msg(input logic k, input logic [7:0] seed);
      msg_kind = k;
      for (int b = 0; b < 16; b++) msg_hdr[127-8*b -: 8] = seed + 8'(b);
      msg_payload = {seed, 8'hA5, seed, 8'h5A};
      msg_valid = 1'b1;
   endtask

   task automatic wr_ctl(input logic [31:0] d);
      reg_addr = A_CTL; reg_wdata = d; reg_wr = 1'b1;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] lfsr;
      idle();
      repeat (3) step();
      rst_n = 1'b1;

      // R10: reset state
      rd(A_CTL, v);  chk("R10 ctrl", v, 32'd0);
      rd(A_H0, v);   chk("R10 hdr0", v, 32'd0);
      rd(A_H3, v);   chk("R10 hdr3", v, 32'd0);
      rd(A_PAY, v);  chk("R10 payload", v, 32'd0);
      chk("R10 ready", {31'd0, msg_ready}, 32'd1);
      chk("R10 irq", {31'd0, vdm_irq}, 32'd0);
      chk("R10 ur", {31'd0, ur_pulse}, 32'd0);

      wr_ctl(32'h4); step(); idle();

      // first capture
      put_msg(1'b1, 8'h10); step(); idle();
      rd(A_CTL, v);  chk("R3 flag set", v, 32'h5);
      rd(A_H3, v);   chk("R2 hdr3 bytes", v, 32'h1c1d1e1f);
      rd(A_H0, v);   chk("R2 hdr0 bytes", v, 32'h10111213);
      rd(A_PAY, v);  chk("R1 payload", v, 32'h10A5105A);
      chk("R9 irq on", {31'd0, vdm_irq}, 32'd1);

      // held while flag set
      step();
      put_msg(1'b0, 8'h40);
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R4 stalled", {31'd0, msg_ready}, 32'd0);
      end
      rd(A_PAY, v); chk("R4 payload kept", v, 32'h10A5105A);
      step();
      wr_ctl(32'h5); step(); reg_wr = 1'b0;
      chk("R4 released", {31'd0, msg_ready}, 32'd1);
      step(); idle();
      rd(A_PAY, v); chk("R4 pending taken", v, 32'h40A5405A);

      // clear and capture in the same cycle
      step();
      wr_ctl(32'h5); step(); reg_wr = 1'b0;
      put_msg(1'b1, 8'h70); wr_ctl(32'h5); step(); idle();
      rd(A_CTL, v); chk("R5 capture wins", v, 32'h5);
      rd(A_PAY, v); chk("R1 payload 3", v, 32'h70A5705A);
      step();
      wr_ctl(32'h4); step(); idle();
      rd(A_CTL, v); chk("R5 write zero keeps", v, 32'h5);

      // mask releases a held type 0 message as unsupported request
      step();
      put_msg(1'b0, 8'h90); wr_ctl(32'h6); step(); reg_wr = 1'b0;
      chk("R6 ready when masked", {31'd0, msg_ready}, 32'd1);
      chk("R9 irq masked", {31'd0, vdm_irq}, 32'd0);
      step(); idle();
      chk("R7 ur pulse", {31'd0, ur_pulse}, 32'd1);
      step();
      chk("R7 ur one cycle", {31'd0, ur_pulse}, 32'd0);
      rd(A_PAY, v); chk("R6 payload kept", v, 32'h70A5705A);
      rd(A_CTL, v); chk("R6 flag kept", v, 32'h7);

      // masked type 1 is silent
      step();
      put_msg(1'b1, 8'hB0); step(); idle();
      chk("R8 no ur", {31'd0, ur_pulse}, 32'd0);
      step();
      chk("R8 no ur later", {31'd0, ur_pulse}, 32'd0);
      rd(A_H0, v); chk("R8 hdr kept", v, 32'h70717273);

      // read-only payload register
      step();
      reg_addr = A_PAY; reg_wdata = 32'hFFFF_FFFF; reg_wr = 1'b1; step(); idle();
      rd(A_PAY, v); chk("R1 write ignored", v, 32'h70A5705A);

      // unmask with flag still set, then clear
      step();
      wr_ctl(32'h4); step(); idle();
      chk("R4 stalls again", {31'd0, msg_ready}, 32'd0);
      chk("R9 irq back", {31'd0, vdm_irq}, 32'd1);
      wr_ctl(32'h5); step(); idle();
      chk("R5 cleared", {31'd0, msg_ready}, 32'd1);
      chk("R9 irq off", {31'd0, vdm_irq}, 32'd0);

      // pseudo-random traffic checked by the model every cycle
      lfsr = 32'hACE1_2357;
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         msg_valid   = lfsr[0] | lfsr[1];
         msg_kind    = lfsr[2];
         msg_hdr     = {lfsr, ~lfsr, {lfsr[15:0], lfsr[31:16]}, lfsr ^ 32'h5A5A_A5A5};
         msg_payload = ~lfsr;
         reg_addr    = 12'h340 + {7'd0, lfsr[13:11], 2'b00};
         reg_wr      = (lfsr[6:3] == 4'd0);
         if (reg_wr && lfsr[7]) reg_addr = A_CTL;
         reg_wdata   = {29'd0, lfsr[10:8] & {lfsr[14], 2'b11}};
         step();
      end
      idle();
      step();
      finish_up();
   end

endmodule